// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Writer

This block moves received Ethernet frames from a byte stream into memory. Memory holds a ring of two-word descriptors: the first word points at a 128-byte receive buffer, and the second word carries status. For every buffer it is about to fill, the block reads the descriptor's address word. It packs the incoming bytes four at a time into 32-bit writes. When the buffer is full or the frame ends, it writes the status word and then hands the buffer to software by setting the ownership bit in the address word. A frame longer than one buffer spills into the following descriptors, and a descriptor flagged as last sends the walk back to the ring base.

Software clears the ownership bit to give a buffer back. The block re-reads ownership every time, so a buffer that is still held stops the frame. The rest of that frame is drained from the stream and discarded, and an overrun pulse is raised. The ring base is a register that can be loaded only while the block is disabled. Each enable restarts the walk at that base.

Top module: `rxr_dma_writer`

## Requirements
- R1: After reset, `s_ready`, `mem_req`, `frame_rx` and `overrun` are low.
- R2: A buffer's memory address is the descriptor's first word with bits 1:0 forced to zero. Byte k of a buffer lands at byte lane k mod 4 (lane 0 = bits 7:0) of the word at buffer + 4*(k div 4). In the final word, lanes past the end of the frame are written as zero.
- R3: Before each buffer the block reads the address word at the descriptor pointer, and writes the status word at pointer+4. It then rewrites the address word with bit 0 set and all other bits preserved.
- R4: Bit 14 of the status word is set only in a frame's first buffer, and bit 15 only in its final buffer. The final buffer also carries the total byte count in bits 11:0. A middle buffer's status word is zero.
- R5: Each buffer takes 128 bytes before the frame moves on to the next descriptor, 8 bytes further on. A descriptor whose address word has bit 1 set is followed by the descriptor at the ring base.
- R6: If the first six bytes of a frame are all 0xFF, the final status word has bit 31 set.
- R7: A frame whose last byte carries `s_err` gets bit 16 set in its final status word.
- R8: If the address word read has bit 0 set, the block pulses `overrun` for one cycle. It writes nothing more for that frame, drains the frame's remaining bytes through to `s_last`, and leaves its pointer on that descriptor, which it reads again for the next frame.
- R9: `frame_rx` pulses for one cycle when the final buffer's address-word write completes. It never coincides with `overrun`.
- R10: A base pointer write is ignored while `enable` is high. Bits 2:0 of the base are forced to zero. Each rising edge of `enable` reloads the descriptor pointer from the base.
- R11: While `enable` is low, no frame is started: `s_ready` and `mem_req` stay low.
- R12: `mem_req` holds its address, write flag and write data steady until `mem_ack`, always uses word-aligned addresses, and is never high while `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Receive enable |
| base_wr | input | 1 | Base pointer load strobe |
| base_wdata | input | 32 | Base pointer value |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of frame |
| s_err | input | 1 | Frame error, sampled with the final byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory request complete |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| frame_rx | output | 1 | Frame stored pulse |
| overrun | output | 1 | Buffer unavailable pulse |

## Verification
The two functions that can fall on the same cycle are the final ownership hand-off of one frame and the ownership read at the start of the next. Another case is a frame that crosses the ring's wrap point just as it reaches a descriptor that software has not yet returned. The bench provokes both. It sends back-to-back frames, frames that cross the wrap, and a frame whose continuation buffer is still owned. A scoreboard then compares every descriptor and buffer in its memory model at the instant `frame_rx` or `overrun` pulses. The bench also checks which of the two events arrived, so that a partly filled frame can never pass as a completed one.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_FILL,
      ST_WDATA,
      ST_WSTAT,
      ST_WADDR,
      ST_DROP
   } rxr_state_e;

   localparam int OWN_BIT       = 0;
   localparam int LAST_DESC_BIT = 1;
   localparam int SOF_BIT       = 14;
   localparam int EOF_BIT       = 15;
   localparam int ERR_BIT       = 16;
   localparam int BCAST_BIT     = 31;
   localparam int DESC_STRIDE   = 8;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
   parameter int STRIDE = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        enable,
   input  logic        base_wr,
   input  logic [31:0] base_wdata,
   input  logic        advance,
   input  logic        wrap,
   output logic [31:0] ptr,
   output logic        run
);
   logic        enable_q;
   logic [31:0] base_q;
   logic        unused_lo;

   assign unused_lo = ^base_wdata[2:0];
   assign run = enable && enable_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable_q <= 1'b0;
         base_q   <= '0;
         ptr      <= '0;
      end else begin
         enable_q <= enable;
         if (base_wr && !enable)
            base_q <= {base_wdata[31:3], 3'b000};
         if (enable && !enable_q)
            ptr <= base_q;
         else if (advance)
            ptr <= wrap ? base_q : ptr + 32'(STRIDE);
      end
   end
endmodule

// File: rtl/rxr_pack.sv
module rxr_pack (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        push,
   input  logic [1:0]  lane,
   input  logic [7:0]  byte_in,
   output logic [31:0] word
);
   for (genvar g = 0; g < 4; g++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            lane_q <= '0;
         else if (clear)
            lane_q <= '0;
         else if (push && lane == 2'(g))
            lane_q <= byte_in;
      end
      assign word[8*g +: 8] = lane_q;
   end
endmodule

// File: rtl/rxr_bcast.sv
module rxr_bcast #(
   parameter int LEN_W    = 12,
   parameter int DETECT   = 1,
   parameter int DA_BYTES = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             push,
   input  logic [7:0]       byte_in,
   input  logic [LEN_W-1:0] len,
   output logic             is_bcast
);
   if (DETECT != 0) begin : g_det
      logic all_ones;
      always_ff @(posedge clk) begin
         if (!rst_n)
            all_ones <= 1'b0;
         else if (arm)
            all_ones <= 1'b1;
         else if (push && len < LEN_W'(DA_BYTES) && byte_in != 8'hFF)
            all_ones <= 1'b0;
      end
      assign is_bcast = all_ones && (len >= LEN_W'(DA_BYTES));
   end else begin : g_none
      logic unused_in;
      assign unused_in = ^{clk, rst_n, arm, push, byte_in, len};
      assign is_bcast  = 1'b0;
   end
endmodule

// File: rtl/rxr_dma_writer.sv
module rxr_dma_writer
   import rxr_pkg::*;
#(
   parameter int BUF_BYTES    = 128,
   parameter int LEN_W        = 12,
   parameter int BCAST_DETECT = 1,
   parameter int DA_BYTES     = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        enable,
   input  logic        base_wr,
   input  logic [31:0] base_wdata,
   input  logic        s_valid,
   output logic        s_ready,
   input  logic [7:0]  s_data,
   input  logic        s_last,
   input  logic        s_err,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic        mem_ack,
   input  logic [31:0] mem_rdata,
   output logic        frame_rx,
   output logic        overrun
);
   localparam int BOFF_W = $clog2(BUF_BYTES) + 1;
   localparam int WIDX_W = BOFF_W - 2;
   localparam logic [BOFF_W-1:0] BOFF_FULL = BOFF_W'(BUF_BYTES);

   if (BUF_BYTES < 8 || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_buf
      $fatal(1, "BUF_BYTES must be a power of two of at least 8");
   end
   if (LEN_W < 8 || LEN_W > SOF_BIT) begin : g_bad_len
      $fatal(1, "LEN_W must lie between 8 and the start flag position");
   end

   rxr_state_e        state;
   logic [BOFF_W-1:0] boff;
   logic [WIDX_W-1:0] widx;
   logic [LEN_W-1:0]  len;
   logic [31:0]       desc_addr;
   logic              first, fin, err_q;
   logic [31:0]       ptr, word, stat, buf_base;
   logic              run, is_bcast, accept;

   assign accept   = (state == ST_FILL) && s_valid;
   assign s_ready  = (state == ST_FILL) || (state == ST_DROP);
   assign buf_base = {desc_addr[31:2], 2'b00};
   assign frame_rx = (state == ST_WADDR) && mem_ack && fin;
   assign overrun  = (state == ST_FETCH) && mem_ack && mem_rdata[OWN_BIT];

   rxr_ring_ptr #(.STRIDE(DESC_STRIDE)) u_ring (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .base_wr(base_wr), .base_wdata(base_wdata),
      .advance((state == ST_WADDR) && mem_ack),
      .wrap(desc_addr[LAST_DESC_BIT]),
      .ptr(ptr), .run(run)
   );

   rxr_pack u_pack (
      .clk(clk), .rst_n(rst_n),
      .clear((state == ST_WDATA) && mem_ack),
      .push(accept), .lane(boff[1:0]), .byte_in(s_data), .word(word)
   );

   rxr_bcast #(.LEN_W(LEN_W), .DETECT(BCAST_DETECT), .DA_BYTES(DA_BYTES)) u_bcast (
      .clk(clk), .rst_n(rst_n), .arm(state == ST_IDLE),
      .push(accept), .byte_in(s_data), .len(len), .is_bcast(is_bcast)
   );

   always_comb begin
      stat          = '0;
      stat[SOF_BIT] = first;
      if (fin) begin
         stat[EOF_BIT]     = 1'b1;
         stat[LEN_W-1:0]   = len;
         stat[ERR_BIT]     = err_q;
         stat[BCAST_BIT]   = is_bcast;
      end
   end

   always_comb begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = ptr;
      mem_wdata = '0;
      unique case (state)
         ST_FETCH: mem_we = 1'b0;
         ST_WDATA: begin
            mem_addr  = buf_base + (32'(widx) << 2);
            mem_wdata = word;
         end
         ST_WSTAT: begin
            mem_addr  = ptr + 32'd4;
            mem_wdata = stat;
         end
         ST_WADDR: mem_wdata = desc_addr | 32'd1;
         default: begin
            mem_req = 1'b0;
            mem_we  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         boff      <= '0;
         widx      <= '0;
         len       <= '0;
         desc_addr <= '0;
         first     <= 1'b0;
         fin       <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (run && s_valid) begin
               state <= ST_FETCH;
               first <= 1'b1;
               fin   <= 1'b0;
               err_q <= 1'b0;
               len   <= '0;
            end
            ST_FETCH: if (mem_ack) begin
               desc_addr <= mem_rdata;
               boff      <= '0;
               widx      <= '0;
               state     <= mem_rdata[OWN_BIT] ? ST_DROP : ST_FILL;
            end
            ST_FILL: if (accept) begin
               boff <= boff + 1'b1;
               len  <= len + 1'b1;
               if (s_last) begin
                  fin   <= 1'b1;
                  err_q <= s_err;
               end
               if (s_last || boff[1:0] == 2'd3)
                  state <= ST_WDATA;
            end
            ST_WDATA: if (mem_ack) begin
               widx  <= widx + 1'b1;
               state <= (fin || boff == BOFF_FULL) ? ST_WSTAT : ST_FILL;
            end
            ST_WSTAT: if (mem_ack) state <= ST_WADDR;
            ST_WADDR: if (mem_ack) begin
               first <= 1'b0;
               state <= fin ? ST_IDLE : ST_FETCH;
            end
            ST_DROP: if (s_valid && s_last) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxr_dma_writer_chk.sv
module rxr_dma_writer_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        s_ready,
   input logic        mem_req,
   input logic        mem_we,
   input logic [31:0] mem_addr,
   input logic [31:0] mem_wdata,
   input logic        mem_ack,
   input logic [31:0] mem_rdata,
   input logic        frame_rx,
   input logic        overrun
);
   a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   a_r12_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00);

   a_r12_no_req_while_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && s_ready));

   a_r9_done_on_owned_write: assert property (@(posedge clk) disable iff (!rst_n)
      frame_rx |-> mem_req && mem_we && mem_ack && mem_wdata[0]);

   a_r8_overrun_on_owned_read: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> mem_req && !mem_we && mem_ack && mem_rdata[0]);

   a_r9_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_rx && overrun));
endmodule

bind rxr_dma_writer rxr_dma_writer_chk u_chk (
   .clk(clk), .rst_n(rst_n), .s_ready(s_ready),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
   .frame_rx(frame_rx), .overrun(overrun)
);

// File: tb/rxr_dma_writer_tb_top.sv
module rxr_dma_writer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0, base_wr = 1'b0;
   logic [31:0] base_wdata = '0;
   logic        s_valid = 1'b0, s_last = 1'b0, s_err = 1'b0;
   logic [7:0]  s_data = '0;
   logic        s_ready, mem_req, mem_we, mem_ack, frame_rx, overrun;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   logic [31:0] mem [0:1023];
   int n_chk = 0, n_bad = 0, ev_cnt = 0, n_frames = 0, n_ovr = 0, bad_align = 0;
   bit done = 0;

   typedef struct {
      int kind; int dadr; logic [31:0] aw; logic [31:0] stat;
      int nb; int foff; int seed; bit bc; string rq;
   } exp_t;
   exp_t q[$];

   always #5 clk = ~clk;

   rxr_dma_writer dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .base_wr(base_wr), .base_wdata(base_wdata),
      .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last), .s_err(s_err),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .frame_rx(frame_rx), .overrun(overrun)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
      end else if (mem_req && !mem_ack) begin
         if (mem_addr[1:0] != 2'b00) bad_align++;
         mem_ack   <= 1'b1;
         mem_rdata <= mem[mem_addr[11:2]];
         if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      end else begin
         mem_ack <= 1'b0;
      end
   end

   task automatic check(bit ok, string rq, string what, logic [31:0] act, logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
      end
   endtask

   function automatic logic [7:0] fb(int seed, int i, bit bc);
      if (bc && i < 6) return 8'hFF;
      return 8'((seed * 17 + i) & 8'h7F);
   endfunction

   task automatic expect_desc(int kind, int dadr, logic [31:0] aw, logic [31:0] stat,
                              int nb, int foff, int seed, bit bc, string rq);
      exp_t e;
      e.kind = kind; e.dadr = dadr; e.aw = aw; e.stat = stat;
      e.nb = nb; e.foff = foff; e.seed = seed; e.bc = bc; e.rq = rq;
      q.push_back(e);
   endtask

   // monitor: on every completion event, compare queued descriptor expectations
   always @(negedge clk) begin
      if (rst_n && (frame_rx || overrun)) begin
         int kind;
         kind = frame_rx ? 0 : 1;
         ev_cnt++;
         if (frame_rx) n_frames++;
         if (overrun) n_ovr++;
         while (q.size() > 0) begin
            exp_t it;
            int bad;
            int bufa;
            it = q.pop_front();
            bad = 0;
            check(kind == it.kind, it.rq, "event kind (0 frame, 1 overrun)", 32'(kind), 32'(it.kind));
            check(mem[it.dadr >> 2] == it.aw, it.rq, "address word", mem[it.dadr >> 2], it.aw);
            check(mem[(it.dadr >> 2) + 1] == it.stat, it.rq, "status word",
                  mem[(it.dadr >> 2) + 1], it.stat);
            if (it.nb > 0) begin
               bufa = int'(it.aw & 32'hFFFF_FFFC);
               for (int w = 0; w < (it.nb + 3) / 4; w++) begin
                  logic [31:0] ew;
                  ew = '0;
                  for (int k = 0; k < 4; k++)
                     if (4 * w + k < it.nb) ew[8*k +: 8] = fb(it.seed, it.foff + 4 * w + k, it.bc);
                  if (mem[(bufa >> 2) + w] != ew) bad++;
               end
               check(bad == 0, "R2", "buffer words mismatched", 32'(bad), 32'd0);
            end
         end
      end
   end

   task automatic send(int nb, bit bc, bit er, int seed);
      for (int i = 0; i < nb; i++) begin
         s_valid = 1'b1;
         s_data  = fb(seed, i, bc);
         s_last  = (i == nb - 1);
         s_err   = er && (i == nb - 1);
         while (!s_ready) @(negedge clk);
         @(posedge clk);
         @(negedge clk);
      end
      s_valid = 1'b0; s_last = 1'b0; s_err = 1'b0;
   endtask

   task automatic wait_ev(int target);
      while (ev_cnt < target) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic init_ring(int base, int bufb, int n);
      for (int i = 0; i < n; i++) begin
         mem[(base >> 2) + 2 * i]     = 32'(bufb + 128 * i) | ((i == n - 1) ? 32'd2 : 32'd0);
         mem[(base >> 2) + 2 * i + 1] = '0;
      end
   endtask

   task automatic give_back(int dadr);
      mem[dadr >> 2] = mem[dadr >> 2] & 32'hFFFF_FFFE;
   endtask

   initial begin
      int dis_bad;
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      init_ring(32'h100, 32'h400, 4);
      repeat (3) @(negedge clk);
      check(!s_ready && !mem_req && !frame_rx && !overrun, "R1", "outputs after reset",
            {28'd0, s_ready, mem_req, frame_rx, overrun}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      base_wr = 1'b1; base_wdata = 32'h100;
      @(negedge clk);
      base_wr = 1'b0;
      enable = 1'b1;
      repeat (2) @(negedge clk);

      // F1: single buffer, broadcast destination
      expect_desc(0, 32'h100, 32'h401, 32'h8000_C03C, 60, 0, 1, 1, "R3 R4 R6");
      send(60, 1, 0, 1); wait_ev(1);
      // F2: two buffers
      expect_desc(0, 32'h108, 32'h481, 32'h0000_4000, 128, 0, 2, 0, "R4 R5");
      expect_desc(0, 32'h110, 32'h501, 32'h0000_80C8, 72, 128, 2, 0, "R4 R5");
      send(200, 0, 0, 2); wait_ev(2);
      // F3: continuation wraps onto a still-owned descriptor
      expect_desc(1, 32'h118, 32'h583, 32'h0000_4000, 128, 0, 3, 0, "R8 R5");
      expect_desc(1, 32'h100, 32'h401, 32'h8000_C03C, 0, 0, 0, 0, "R8");
      send(300, 0, 0, 3); wait_ev(3);
      give_back(32'h100); give_back(32'h108); give_back(32'h110);
      // F4: error on last byte, index re-read at d0
      expect_desc(0, 32'h100, 32'h401, 32'h0000_4000, 128, 0, 4, 0, "R8 R7");
      expect_desc(0, 32'h108, 32'h481, 32'h0001_8082, 2, 128, 4, 0, "R7");
      send(130, 0, 1, 4); wait_ev(4);
      give_back(32'h118); give_back(32'h100);
      // F5: three buffers across wrap, middle status zero
      expect_desc(0, 32'h110, 32'h501, 32'h0000_4000, 128, 0, 5, 0, "R5");
      expect_desc(0, 32'h118, 32'h583, 32'h0000_0000, 128, 128, 5, 0, "R4 R5");
      expect_desc(0, 32'h100, 32'h401, 32'h0000_8104, 4, 256, 5, 0, "R5 R2");
      send(260, 0, 0, 5); wait_ev(5);
      // F6: owned at frame start
      expect_desc(1, 32'h108, 32'h481, 32'h0001_8082, 0, 0, 0, 0, "R8");
      send(20, 0, 0, 6); wait_ev(6);
      give_back(32'h108);
      // F7: same descriptor after return
      expect_desc(0, 32'h108, 32'h481, 32'h0000_C014, 20, 0, 7, 0, "R8 R9");
      send(20, 0, 0, 7); wait_ev(7);

      // disabled: no start
      enable = 1'b0;
      repeat (2) @(negedge clk);
      s_valid = 1'b1; s_data = 8'h55; s_last = 1'b1;
      dis_bad = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (s_ready || mem_req) dis_bad++;
      end
      check(dis_bad == 0, "R11", "ready or request while disabled", 32'(dis_bad), 32'd0);
      s_valid = 1'b0; s_last = 1'b0;
      @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      base_wr = 1'b1; base_wdata = 32'h200;
      @(negedge clk);
      base_wr = 1'b0;
      for (int i = 0; i < 4; i++) give_back(32'h100 + 8 * i);
      @(negedge clk);
      // F8: base write while enabled ignored, index back at old base
      expect_desc(0, 32'h100, 32'h401, 32'h0000_C028, 40, 0, 8, 0, "R10");
      send(40, 0, 0, 8); wait_ev(8);

      enable = 1'b0;
      @(negedge clk);
      base_wr = 1'b1; base_wdata = 32'h205;
      @(negedge clk);
      base_wr = 1'b0;
      init_ring(32'h200, 32'h800, 2);
      enable = 1'b1;
      repeat (2) @(negedge clk);
      // F9: new base with low bits masked
      expect_desc(0, 32'h200, 32'h801, 32'h0000_4000, 128, 0, 9, 0, "R10");
      expect_desc(0, 32'h208, 32'h883, 32'h0000_8096, 22, 128, 9, 0, "R10 R5");
      send(150, 0, 0, 9); wait_ev(9);
      give_back(32'h200);
      // F10: wrap returns to the new base
      expect_desc(0, 32'h200, 32'h801, 32'h0000_C00A, 10, 0, 10, 0, "R5");
      send(10, 0, 0, 10); wait_ev(10);

      check(n_frames == 8, "R9", "frame_rx pulses", 32'(n_frames), 32'd8);
      check(n_ovr == 2, "R8", "overrun pulses", 32'(n_ovr), 32'd2);
      check(q.size() == 0, "R9", "unmatched expectations", 32'(q.size()), 32'd0);
      check(bad_align == 0, "R12", "unaligned requests", 32'(bad_align), 32'd0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R9 watchdog: actual %0d events expected 10", ev_cnt);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule